// File: doc/BRIEF.md
# Path Signal Label Monitor

The block watches the path signal label byte that arrives once per frame. A byte counts only on a cycle where the frame strobe is high. A label is accepted only when the same byte has arrived in a run of consecutive frames. The accepted label is kept in a register and compared with a programmed expected label.

Two defect flags come out of that comparison. The first is a payload label mismatch. The second flags an unequipped path, which the block raises when the all-zero label arrives while a nonzero label is expected. Four label codes never raise a mismatch: the all-zero code, the generic "equipped" code and the two reserved codes at the top of the range.

Three sticky change bits record events for later polling: a new label was accepted, the mismatch flag changed, and the unequipped flag changed. Software clears each bit by writing a one to it.

Top module: `slm_label_monitor`

## Requirements
- R1: A label is accepted only after PERSIST_N (default 5) consecutive strobed frames carry the same byte. `acc_label` takes that byte at the clock edge that registers the completing frame.
- R2: A strobed byte that differs from the previous strobed byte restarts the run count at one, with the new byte counted as the first of its run.
- R3: `acc_delta` is set when an accepted byte differs from the stored label. Accepting again a byte equal to the stored label leaves `acc_delta` unchanged.
- R4: `plm` is high exactly when a label has been accepted, the accepted label differs from `exp_label`, and the accepted label is none of 0x00, 0x01, 0xFC or 0xFF. The flag follows one clock after `acc_label` or `exp_label` changes.
- R5: `uneq` is high exactly when a label has been accepted, the accepted label is 0x00 and `exp_label` is not 0x00. It has the same one-clock latency as `plm`.
- R6: `plm_delta` is set on every change of `plm`, and `uneq_delta` on every change of `uneq`, rising or falling.
- R7: `delta_clr` clears the delta bits bit by bit: bit 0 clears `acc_delta`, bit 1 clears `plm_delta`, bit 2 clears `uneq_delta`. A set event in the same cycle wins over the clear.
- R8: After reset, `acc_label` is 0x00 and all flags and delta bits are low. The flags stay low until the first acceptance, whatever `exp_label` holds.
- R9: `rx_label` is ignored on cycles where `frame_stb` is low. Such cycles neither advance nor break a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | Marks the cycle carrying this frame's label byte |
| rx_label | input | 8 | Received label byte |
| exp_label | input | 8 | Programmed expected label |
| delta_clr | input | 3 | Write-one-to-clear for {uneq, plm, accept} deltas |
| acc_label | output | 8 | Currently accepted label |
| plm | output | 1 | Payload label mismatch flag |
| uneq | output | 1 | Unequipped flag |
| acc_delta | output | 1 | Sticky: new label accepted |
| plm_delta | output | 1 | Sticky: `plm` changed |
| uneq_delta | output | 1 | Sticky: `uneq` changed |

## Verification
The bench uses the default persistence of five frames and 8-bit labels. At that setting a run broken at its fourth frame, the exact fifth-frame acceptance and the saturated re-acceptance of a held label are all reachable in a few dozen frames. These settings also reach each of the four exempt codes against a nonzero expected label. Idle cycles between strobes carry a deliberately different byte, so ignoring unstrobed data is exercised on every frame.

// File: rtl/slm_pkg.sv
package slm_pkg;
  localparam int LBL_W = 8;
  typedef logic [LBL_W-1:0] label_t;

  localparam label_t LBL_NONE    = 8'h00;
  localparam label_t LBL_GENERIC = 8'h01;
  localparam label_t LBL_RSV_LO  = 8'hFC;
  localparam label_t LBL_RSV_HI  = 8'hFF;

  // Codes that never count as a mismatch.
  function automatic logic label_exempt(input label_t l);
    return (l == LBL_NONE) || (l == LBL_GENERIC) || (l == LBL_RSV_LO) || (l == LBL_RSV_HI);
  endfunction

  function automatic logic label_mismatch(input label_t acc, input label_t expv, input logic have);
    return have && (acc != expv) && !label_exempt(acc);
  endfunction

  function automatic logic label_unequipped(input label_t acc, input label_t expv, input logic have);
    return have && (acc == LBL_NONE) && (expv != LBL_NONE);
  endfunction

  // Run length after one more strobed byte, saturating at lim.
  function automatic int unsigned next_run(input logic repeat_byte, input int unsigned run,
                                           input int unsigned lim);
    if (!repeat_byte) return 1;
    return (run >= lim) ? lim : run + 1;
  endfunction
endpackage

// File: rtl/slm_persist.sv
module slm_persist #(
  parameter int PERSIST_N = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  slm_pkg::label_t din,
  output logic            accept_fire,
  output slm_pkg::label_t accept_val
);
  import slm_pkg::*;
  localparam int CNT_W = $clog2(PERSIST_N + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(PERSIST_N);

  label_t           prev_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nx;
  logic             repeat_byte;

  assign repeat_byte = (run_q != '0) && (din == prev_q);
  assign run_nx      = CNT_W'(next_run(repeat_byte, int'(run_q), PERSIST_N));
  assign accept_fire = stb && (run_nx >= LIM);
  assign accept_val  = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      run_q  <= '0;
    end else if (stb) begin
      prev_q <= din;
      run_q  <= run_nx;
    end
  end

  // R2: a differing byte starts a fresh run of one
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    stb && (din != prev_q) |=> run_q == CNT_W'(1));
  // R9: no strobe, no change to the run
  a_r9_hold_run: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(run_q) && $stable(prev_q));
endmodule

// File: rtl/slm_classify.sv
module slm_classify (
  input  logic            clk,
  input  logic            rst_n,
  input  slm_pkg::label_t acc,
  input  slm_pkg::label_t expv,
  input  logic            have,
  output logic            plm_q,
  output logic            uneq_q,
  output logic            plm_chg,
  output logic            uneq_chg
);
  import slm_pkg::*;
  logic plm_nx, uneq_nx;

  assign plm_nx   = label_mismatch(acc, expv, have);
  assign uneq_nx  = label_unequipped(acc, expv, have);
  assign plm_chg  = plm_nx != plm_q;
  assign uneq_chg = uneq_nx != uneq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plm_q  <= 1'b0;
      uneq_q <= 1'b0;
    end else begin
      plm_q  <= plm_nx;
      uneq_q <= uneq_nx;
    end
  end

  // R4/R5: the two defects never coexist
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(plm_q && uneq_q));
  // R8: nothing flagged before a label is held
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !have |=> !plm_q && !uneq_q);
endmodule

// File: rtl/slm_sticky.sv
module slm_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  // R7: set beats clear; clear alone drops the bit
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n) set |=> q);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n) clr && !set |=> !q);
endmodule

// File: rtl/slm_label_monitor.sv
module slm_label_monitor #(
  parameter int PERSIST_N = 5,
  parameter int N_DELTA   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_stb,
  input  logic [slm_pkg::LBL_W-1:0] rx_label,
  input  logic [slm_pkg::LBL_W-1:0] exp_label,
  input  logic [N_DELTA-1:0]       delta_clr,
  output logic [slm_pkg::LBL_W-1:0] acc_label,
  output logic                     plm,
  output logic                     uneq,
  output logic                     acc_delta,
  output logic                     plm_delta,
  output logic                     uneq_delta
);
  import slm_pkg::*;

  logic         accept_fire;
  label_t       accept_val;
  label_t       acc_q;
  logic         have_q;
  logic         acc_new;
  logic         plm_chg, uneq_chg;
  logic [N_DELTA-1:0] set_vec, dq;

  slm_persist #(.PERSIST_N(PERSIST_N)) u_persist (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .din(rx_label),
    .accept_fire(accept_fire), .accept_val(accept_val)
  );

  assign acc_new = accept_fire && (accept_val != acc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      have_q <= 1'b0;
    end else if (accept_fire) begin
      acc_q  <= accept_val;
      have_q <= 1'b1;
    end
  end

  slm_classify u_class (
    .clk(clk), .rst_n(rst_n), .acc(acc_q), .expv(exp_label), .have(have_q),
    .plm_q(plm), .uneq_q(uneq), .plm_chg(plm_chg), .uneq_chg(uneq_chg)
  );

  assign set_vec = {uneq_chg, plm_chg, acc_new};

  for (genvar i = 0; i < N_DELTA; i++) begin : g_delta
    slm_sticky u_bit (
      .clk(clk), .rst_n(rst_n), .set(set_vec[i]), .clr(delta_clr[i]), .q(dq[i])
    );
  end

  assign acc_label  = acc_q;
  assign acc_delta  = dq[0];
  assign plm_delta  = dq[1];
  assign uneq_delta = dq[2];

  // R1: the label moves only on a strobed frame, to that frame's byte
  a_r1_from_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_label != $past(acc_label)) |-> $past(frame_stb) && acc_label == $past(rx_label));
  // R3: every label change leaves the accept delta set
  a_r3_delta_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_label != $past(acc_label)) |-> acc_delta);
  // R6: every flag change leaves its delta set
  a_r6_plm_delta: assert property (@(posedge clk) disable iff (!rst_n)
    (plm != $past(plm)) |-> plm_delta);
  a_r6_uneq_delta: assert property (@(posedge clk) disable iff (!rst_n)
    (uneq != $past(uneq)) |-> uneq_delta);
  // R9: label held across unstrobed cycles
  a_r9_hold_label: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(acc_label));
endmodule

// File: tb/sim_slm_label_monitor.sv
module sim_slm_label_monitor;
  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [7:0] rx_label = 8'h00;
  logic [7:0] exp_label = 8'h00;
  logic [2:0] delta_clr = 3'b000;
  logic [7:0] acc_label;
  logic       plm, uneq, acc_delta, plm_delta, uneq_delta;

  always #10 clk = ~clk;

  slm_label_monitor #(.PERSIST_N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_label(rx_label),
    .exp_label(exp_label), .delta_clr(delta_clr), .acc_label(acc_label),
    .plm(plm), .uneq(uneq), .acc_delta(acc_delta), .plm_delta(plm_delta),
    .uneq_delta(uneq_delta)
  );

  typedef struct {
    logic [7:0] acc;
    logic plm, uneq, da, dp, du;
    string scen;
  } exp_t;

  exp_t sb[$];
  event ev;
  int   n_run = 0, n_fail = 0;

  // reference model state
  logic [7:0] m_prev = 0, m_acc = 0;
  int         m_cnt = 0;
  logic       m_have = 0, m_plm = 0, m_uneq = 0, m_da = 0, m_dp = 0, m_du = 0;

  function automatic logic exempt(input logic [7:0] v);
    return v == 8'h00 || v == 8'h01 || v == 8'hFC || v == 8'hFF;
  endfunction

  task automatic chk(input string tag, input string scen, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, expv);
    end
  endtask

  task automatic flags_update();
    logic np, nu;
    np = m_have && (m_acc != exp_label) && !exempt(m_acc);
    nu = m_have && (m_acc == 8'h00) && (exp_label != 8'h00);
    if (np != m_plm) m_dp = 1;
    if (nu != m_uneq) m_du = 1;
    m_plm = np;
    m_uneq = nu;
  endtask

  task automatic push(input string scen);
    exp_t e;
    e.acc = m_acc; e.plm = m_plm; e.uneq = m_uneq;
    e.da = m_da; e.dp = m_dp; e.du = m_du; e.scen = scen;
    sb.push_back(e);
    -> ev;
  endtask

  // driver: one strobed frame, optional clear in the same cycle
  task automatic frame(input logic [7:0] lbl, input logic [2:0] clr, input string scen);
    @(negedge clk);
    rx_label = lbl; frame_stb = 1'b1; delta_clr = clr;
    if (clr[1]) m_dp = 0;
    if (clr[2]) m_du = 0;
    if (clr[0]) m_da = 0;
    if (m_cnt != 0 && lbl == m_prev) m_cnt = (m_cnt >= N) ? N : m_cnt + 1;
    else m_cnt = 1;
    m_prev = lbl;
    if (m_cnt >= N) begin
      if (lbl != m_acc) m_da = 1;   // R3
      m_acc = lbl;
      m_have = 1;
    end
    @(negedge clk);
    frame_stb = 1'b0; delta_clr = 3'b000; rx_label = ~lbl;  // R9 noise
    flags_update();
    @(negedge clk);
    push(scen);
  endtask

  task automatic frames(input logic [7:0] lbl, input int k, input string scen);
    for (int i = 0; i < k; i++) frame(lbl, 3'b000, scen);
  endtask

  task automatic set_exp(input logic [7:0] v, input string scen);
    @(negedge clk);
    exp_label = v;
    flags_update();
    @(negedge clk);
    @(negedge clk);
    push(scen);
  endtask

  task automatic clear(input logic [2:0] mask, input string scen);
    @(negedge clk);
    delta_clr = mask;
    if (mask[0]) m_da = 0;
    if (mask[1]) m_dp = 0;
    if (mask[2]) m_du = 0;
    @(negedge clk);
    delta_clr = 3'b000;
    push(scen);
  endtask

  // monitor: compares each expected item with the ports
  initial begin
    forever begin
      @(ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk("R1 acc_label", e.scen, acc_label, e.acc);
        chk("R4 plm", e.scen, plm, e.plm);
        chk("R5 uneq", e.scen, uneq, e.uneq);
        chk("R3 acc_delta", e.scen, acc_delta, e.da);
        chk("R6 plm_delta", e.scen, plm_delta, e.dp);
        chk("R6 uneq_delta", e.scen, uneq_delta, e.du);
      end
    end
  end

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    push("R8 reset state");
    set_exp(8'h42, "R8 nonzero expected before first acceptance");
    frames(8'h42, N - 1, "R1 run one short");
    frame(8'h42, 3'b000, "R1 fifth frame accepts");
    clear(3'b111, "R7 clear all deltas");
    frames(8'h42, 2, "R3 re-accept equal label");
    frames(8'h33, 3, "R2 run start");
    frame(8'h34, 3'b000, "R2 break");
    frames(8'h33, N - 1, "R2 restarted run short");
    frame(8'h33, 3'b000, "R2 restarted run accepts");
    clear(3'b111, "R7 clear before flag fall");
    set_exp(8'h33, "R6 plm falling edge");
    frames(8'h01, N, "R4 generic code exempt");
    frames(8'hFC, N, "R4 reserved low exempt");
    frames(8'hFF, N, "R4 reserved high exempt");
    clear(3'b111, "R7 clear");
    frames(8'h00, N, "R5 unequipped");
    set_exp(8'h00, "R5 zero expected drops unequipped");
    clear(3'b011, "R7 partial clear");
    frames(8'h77, N - 1, "R7 priority lead-in");
    frame(8'h77, 3'b001, "R7 set beats clear");
    frames(8'h77, 2, "R4 mismatch held");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule